// File: doc/BRIEF.md
# IEEE Double-Precision Compare Unit

This unit takes two 64-bit IEEE 754 binary64 operands and a 2-bit predicate code. It returns a 64-bit verdict word and an invalid-operation flag. Four predicates are supported: equal, less-or-equal, less-than and unordered. A true verdict is the double-precision constant 2.0 (`0x4000000000000000`), not the integer 1. A false verdict is all zeros, so a floating-point branch on the result can test it directly.

The unit handles signed zeros, infinities, subnormals, and quiet and signaling NaNs. The two ordering predicates and the two quiet predicates raise the invalid flag under different rules. One operation is accepted on every cycle in which `cmp_valid` is high. Its verdict and flag appear on the following cycle together with a one-cycle `res_valid` pulse. Rounding, trap delivery and other formats are not part of this block.

Top module: `dcmp_unit`

## Requirements
- R1: An operation presented with `cmp_valid` high produces `res_valid` high exactly one clock later; back-to-back operations yield back-to-back results.
- R2: When `res_valid` is high, `res_word` is `0x4000000000000000` for a true verdict and zero for a false verdict.
- R3: The predicate code on `cmp_pred` is decoded as 0 = equal, 1 = less-or-equal, 2 = less-than, 3 = unordered.
- R4: An operand is a NaN when bits 62..52 are all ones and bits 51..0 are not all zero. It is quiet when bit 51 is set and signaling when bit 51 is clear. An all-ones exponent with zero fraction is an infinity, not a NaN.
- R5: Less-than and less-or-equal with either operand a NaN (quiet or signaling) return false and raise `invalid`.
- R6: Equal and unordered raise `invalid` only when at least one operand is a signaling NaN; quiet NaNs raise nothing.
- R7: Unordered returns true when either operand is a NaN and false otherwise.
- R8: Equal returns false when either operand is a NaN, even when both bit patterns are identical.
- R9: Positive and negative zero compare equal, and neither is less than the other.
- R10: Non-NaN operands are ordered by sign and magnitude, including infinities and subnormals. With the sign bit set, a larger magnitude is the smaller value.
- R11: `invalid` is a per-operation pulse, low whenever `res_valid` is low. `res_word` keeps the last verdict through idle cycles.
- R12: While reset is asserted, `res_valid`, `invalid` and `res_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Operation strobe |
| cmp_pred | input | 2 | Predicate code (0 EQ, 1 LE, 2 LT, 3 UN) |
| opnd_a | input | 64 | First binary64 operand |
| opnd_b | input | 64 | Second binary64 operand |
| res_valid | output | 1 | Result strobe, one cycle after `cmp_valid` |
| res_word | output | 64 | Verdict word: 2.0 for true, zero for false |
| invalid | output | 1 | Invalid-operation pulse for the operation |

## Verification
The hardest situation to reach is the set of sign and magnitude crossings near zero. Examples are a negative subnormal against negative zero, or a negative NaN pattern compared with itself. Random operands almost never land on these encodings. The stimulus table therefore names each encoding explicitly and pairs it with every predicate whose invalid rule differs. It also includes a signaling NaN whose upper fraction bits are set but whose quiet bit is clear. Directed sequences then show that the flag is cleared and the verdict word held across idle cycles after an invalid-raising operation.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LE = 2'd1,
    CMP_LT = 2'd2,
    CMP_UN = 2'd3
  } cmp_pred_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic denorm;
    logic nan;
    logic snan;
  } opnd_class_t;

endpackage

// File: rtl/dcmp_classify.sv
module dcmp_classify
  import dcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output opnd_class_t           cls
);
  localparam int SIGN_POS = EXP_W + FRAC_W;
  localparam int QBIT_POS = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_all1, exp_all0, frac_nz;

  assign exp_f    = val[FRAC_W +: EXP_W];
  assign frac_f   = val[FRAC_W-1:0];
  assign exp_all1 = &exp_f;
  assign exp_all0 = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls        = '0;
    cls.sign   = val[SIGN_POS];
    cls.zero   = exp_all0 & ~frac_nz;
    cls.denorm = exp_all0 & frac_nz;
    cls.inf    = exp_all1 & ~frac_nz;
    cls.nan    = exp_all1 & frac_nz;
    cls.snan   = exp_all1 & frac_nz & ~val[QBIT_POS];
  end
endmodule

// File: rtl/dcmp_order.sv
module dcmp_order
  import dcmp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  opnd_class_t   cls_a,
  input  opnd_class_t   cls_b,
  output logic          a_lt_b,
  output logic          a_eq_b
);
  localparam int MW = DW - 1;

  function automatic logic signed_less(input logic sa, input logic sb,
                                       input logic [MW-1:0] ma,
                                       input logic [MW-1:0] mb);
    logic r;
    unique case ({sa, sb})
      2'b00:   r = (ma < mb);
      2'b11:   r = (ma > mb);
      2'b10:   r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  logic both_zero;
  assign both_zero = cls_a.zero & cls_b.zero;

  always_comb begin
    a_eq_b = both_zero | (a == b);
    if (both_zero) a_lt_b = 1'b0;
    else           a_lt_b = signed_less(cls_a.sign, cls_b.sign, a[MW-1:0], b[MW-1:0]);
  end
endmodule

// File: rtl/dcmp_decide.sv
module dcmp_decide
  import dcmp_pkg::*;
(
  input  cmp_pred_e   pred,
  input  opnd_class_t cls_a,
  input  opnd_class_t cls_b,
  input  logic        a_lt_b,
  input  logic        a_eq_b,
  output logic        verdict,
  output logic        raise_inv
);
  logic unord, any_snan;
  assign unord    = cls_a.nan | cls_b.nan;
  assign any_snan = cls_a.snan | cls_b.snan;

  always_comb begin
    unique case (pred)
      CMP_EQ: begin verdict = ~unord & a_eq_b;            raise_inv = any_snan; end
      CMP_LE: begin verdict = ~unord & (a_lt_b | a_eq_b); raise_inv = unord;    end
      CMP_LT: begin verdict = ~unord & a_lt_b;            raise_inv = unord;    end
      default: begin verdict = unord;                     raise_inv = any_snan; end
    endcase
  end
endmodule

// File: rtl/dcmp_unit.sv
module dcmp_unit
  import dcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_valid,
  input  logic [1:0]              cmp_pred,
  input  logic [EXP_W+FRAC_W:0]   opnd_a,
  input  logic [EXP_W+FRAC_W:0]   opnd_b,
  output logic                    res_valid,
  output logic [EXP_W+FRAC_W:0]   res_word,
  output logic                    invalid
);
  localparam int DW = EXP_W + FRAC_W + 1;
  localparam logic [DW-1:0] TRUE_WORD = {2'b01, {(DW-2){1'b0}}};

  opnd_class_t cls_a_w, cls_b_w;
  logic        lt_w, eq_w, verdict_w, raise_inv_w;
  logic        any_nan_w, any_snan_w;
  cmp_pred_e   pred_w;

  assign pred_w     = cmp_pred_e'(cmp_pred);
  assign any_nan_w  = cls_a_w.nan | cls_b_w.nan;
  assign any_snan_w = cls_a_w.snan | cls_b_w.snan;

  dcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_a_i (.val(opnd_a), .cls(cls_a_w));
  dcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_b_i (.val(opnd_b), .cls(cls_b_w));

  dcmp_order #(.DW(DW)) order_i (
    .a(opnd_a), .b(opnd_b), .cls_a(cls_a_w), .cls_b(cls_b_w),
    .a_lt_b(lt_w), .a_eq_b(eq_w)
  );

  dcmp_decide decide_i (
    .pred(pred_w), .cls_a(cls_a_w), .cls_b(cls_b_w),
    .a_lt_b(lt_w), .a_eq_b(eq_w),
    .verdict(verdict_w), .raise_inv(raise_inv_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      invalid   <= 1'b0;
    end else begin
      res_valid <= cmp_valid;
      invalid   <= cmp_valid & raise_inv_w;
      if (cmp_valid) res_word <= verdict_w ? TRUE_WORD : '0;
    end
  end
endmodule

// File: rtl/dcmp_unit_chk.sv
module dcmp_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_valid,
  input logic [1:0]    cmp_pred,
  input logic          res_valid,
  input logic [DW-1:0] res_word,
  input logic          invalid,
  input logic          any_nan,
  input logic          any_snan,
  input logic          zero_a,
  input logic          zero_b
);
  localparam logic [DW-1:0] TRUE_WORD = {2'b01, {(DW-2){1'b0}}};

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid); // R1
  AST_WORD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_word == '0 || res_word == TRUE_WORD)); // R2
  AST_ORDER_NAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && (cmp_pred == 2'd1 || cmp_pred == 2'd2) && any_nan |=> invalid && res_word == '0); // R5
  AST_QUIET_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && (cmp_pred == 2'd0 || cmp_pred == 2'd3) && !any_snan |=> !invalid); // R6
  AST_UN_NAN_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_pred == 2'd3 && any_nan |=> res_word == TRUE_WORD); // R7
  AST_EQ_NAN_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_pred == 2'd0 && any_nan |=> res_word == '0); // R8
  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_pred == 2'd0 && zero_a && zero_b |=> res_word == TRUE_WORD); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid && !invalid && $stable(res_word)); // R11
endmodule

bind dcmp_unit dcmp_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_pred(cmp_pred),
  .res_valid(res_valid), .res_word(res_word), .invalid(invalid),
  .any_nan(any_nan_w), .any_snan(any_snan_w),
  .zero_a(cls_a_w.zero), .zero_b(cls_b_w.zero)
);

// File: tb/dcmp_unit_tb.sv
module dcmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TRUEW = 64'h4000000000000000;
  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
  localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000, NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001;
  localparam logic [63:0] SNH = 64'h7FF4000000000000, NQN = 64'hFFF8000000000000;
  localparam logic [63:0] DEN = 64'h1, NDEN = 64'h8000000000000001;
  localparam int NV = 28;
  // entry: {tag[3:0], pred[1:0], a, b, expect_true, expect_invalid}
  localparam logic [135:0] TBL [0:NV-1] = '{
    {4'd10, 2'd0, P1, P1, 1'b1, 1'b0},
    {4'd10, 2'd0, P1, P2, 1'b0, 1'b0},
    {4'd9,  2'd0, PZ, NZ, 1'b1, 1'b0},
    {4'd9,  2'd1, PZ, NZ, 1'b1, 1'b0},
    {4'd9,  2'd2, NZ, PZ, 1'b0, 1'b0},
    {4'd10, 2'd2, N2, N1, 1'b1, 1'b0},
    {4'd10, 2'd2, N1, N2, 1'b0, 1'b0},
    {4'd3,  2'd2, P1, P2, 1'b1, 1'b0},
    {4'd3,  2'd1, P2, P1, 1'b0, 1'b0},
    {4'd10, 2'd1, N1, P1, 1'b1, 1'b0},
    {4'd10, 2'd2, DEN, PZ, 1'b0, 1'b0},
    {4'd10, 2'd2, PZ, DEN, 1'b1, 1'b0},
    {4'd10, 2'd2, NDEN, NZ, 1'b1, 1'b0},
    {4'd10, 2'd2, NINF, N2, 1'b1, 1'b0},
    {4'd10, 2'd1, PINF, PINF, 1'b1, 1'b0},
    {4'd10, 2'd2, P2, PINF, 1'b1, 1'b0},
    {4'd8,  2'd0, QN, QN, 1'b0, 1'b0},
    {4'd8,  2'd0, NQN, NQN, 1'b0, 1'b0},
    {4'd6,  2'd0, SN, P1, 1'b0, 1'b1},
    {4'd7,  2'd3, QN, P1, 1'b1, 1'b0},
    {4'd6,  2'd3, P1, SN, 1'b1, 1'b1},
    {4'd7,  2'd3, P1, P2, 1'b0, 1'b0},
    {4'd5,  2'd2, QN, P1, 1'b0, 1'b1},
    {4'd5,  2'd1, P1, QN, 1'b0, 1'b1},
    {4'd5,  2'd1, SN, SN, 1'b0, 1'b1},
    {4'd4,  2'd3, PINF, NINF, 1'b0, 1'b0},
    {4'd4,  2'd0, SNH, P1, 1'b0, 1'b1},
    {4'd4,  2'd3, NQN, P2, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cmp_valid = 1'b0;
  logic [1:0] cmp_pred = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic res_valid, invalid;
  logic [63:0] res_word;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_pred(cmp_pred),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_word(res_word), .invalid(invalid)
  );

  function automatic string req_name(input logic [3:0] k);
    case (k)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic ev, input logic [63:0] ew, input logic ei);
    checks++;
    if (res_valid !== ev || res_word !== ew || invalid !== ei) begin
      errors++;
      $display("FAIL %s: got valid=%0b word=%h inv=%0b, expected valid=%0b word=%h inv=%0b",
               req, res_valid, res_word, invalid, ev, ew, ei);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [63:0] a, input logic [63:0] b);
    cmp_valid = 1'b1; cmp_pred = p; opnd_a = a; opnd_b = b;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", 1'b0, 64'h0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [135:0] e;
      e = TBL[i];
      drive(e[131:130], e[129:66], e[65:2]);
      @(negedge clk);
      cmp_valid = 1'b0;
      check(req_name(e[135:132]), 1'b1, e[1] ? TRUEW : 64'h0, e[0]);
      @(negedge clk);
    end

    // R2: true word is the constant 2.0, false is zero
    drive(2'd2, N1, P1);
    @(negedge clk) cmp_valid = 1'b0;
    check("R2", 1'b1, TRUEW, 1'b0);
    @(negedge clk);

    // R1: back-to-back operations, one result per cycle
    drive(2'd0, P1, P1);
    @(negedge clk);
    check("R1", 1'b1, TRUEW, 1'b0);
    drive(2'd2, P2, P1);
    @(negedge clk);
    check("R1", 1'b1, 64'h0, 1'b0);
    drive(2'd1, QN, P1);
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R1", 1'b1, 64'h0, 1'b1);

    // R11: flag drops and verdict holds while idle, even with changing inputs
    @(negedge clk);
    check("R11", 1'b0, 64'h0, 1'b0);
    drive(2'd3, QN, SN);
    @(negedge clk) cmp_valid = 1'b0;
    check("R11", 1'b1, TRUEW, 1'b1);
    cmp_pred = 2'd0; opnd_a = P1; opnd_b = P2;
    @(negedge clk);
    check("R11", 1'b0, TRUEW, 1'b0);
    @(negedge clk);
    check("R11", 1'b0, TRUEW, 1'b0);

    // R12: reset in the middle clears the outputs
    drive(2'd0, PZ, PZ);
    rst_n = 1'b0;
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R12", 1'b0, 64'h0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule